// File: doc/BRIEF.md
# Dual-Group Vectored Interrupt Controller with Daisy Chain

This block gathers interrupt events from eight receive channels and three transmit channels. It presents them to a host as two independent interrupt groups. Each group keeps its own pending flags and per-channel mask bits. It drives its own active-high request line and joins an external daisy chain through an enable input and an enable output. A single-cycle event pulse from a channel sets that channel's pending flag. The flag stays set until its vector has been handed to the host.

When the host runs an acknowledge cycle for a group, the group checks two things: its chain enable input must be high, and it must hold an unmasked pending request. If both hold, the group answers with a vector that belongs to the winning channel, and that channel's pending flag is cleared. In every other case the group passes the chain enable on to the next device. Among the receivers, the winner comes from a host-written table of priority slots. Among the transmitters, the order is fixed.

Masks, slot table and vector bases arrive as plain inputs from a register file outside this block.

Top module: `irq_vec_daisy`

## Requirements
- R1: A one-cycle high pulse on a bit of `rx_req` or `tx_req` sets that channel's pending flag on the next rising edge. The flag stays set until the channel's vector is delivered.
- R2: `rx_irq` is high exactly while at least one receive channel is pending with its mask bit low. `tx_irq` behaves the same way for the transmit channels. Both lines are combinational from the pending flags and the masks.
- R3: A mask bit of 1 keeps its channel off the request line and out of arbitration, but the pending flag is kept. Clearing the mask bit makes the request visible again in the same cycle.
- R4: A group's chain enable output equals its enable input while the group has no unmasked pending request, and is low while it has one. This path is combinational.
- R5: When `*_iack` and `*_ein` are high at a rising edge and the group has an unmasked pending request, `*_vec_vld` is high after that edge for one cycle per acknowledge. `*_vec` then equals the upper bits of the group's base with the winning channel index in the low bits: 3 index bits for receive, 2 for transmit.
- R6: An acknowledge with the enable input low, or with no unmasked pending request, produces no vector and leaves all pending flags unchanged.
- R7: Receive priority uses `rx_prio`, which holds eight 3-bit slots. Slot k sits in bits [3k+2:3k], and each slot holds a channel number. Slot 0 is the highest priority. The winner is the channel in the lowest-numbered slot that is pending and unmasked. The host is expected to write a permutation of 0 to 7.
- R8: Transmit priority is fixed: channel 0 is highest and channel 2 is lowest.
- R9: The delivered channel's flag clears on the acknowledge edge, so the request line falls one cycle later unless another request remains. A new event for the same channel on that same edge keeps the flag set.
- R10: While `rst_n` is low at a rising edge, all pending flags and both valid outputs are cleared, and incoming events are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rx_req | input | 8 | Receive channel event pulses |
| tx_req | input | 3 | Transmit channel event pulses |
| rx_mask | input | 8 | Receive mask, 1 blocks the channel |
| tx_mask | input | 3 | Transmit mask, 1 blocks the channel |
| rx_prio | input | 24 | Receive priority slots, slot 0 in bits [2:0] |
| rx_vbase | input | 8 | Receive vector base, bits [7:3] used |
| tx_vbase | input | 8 | Transmit vector base, bits [7:2] used |
| rx_iack | input | 1 | Receive group acknowledge strobe |
| rx_ein | input | 1 | Receive group chain enable in |
| rx_eout | output | 1 | Receive group chain enable out |
| rx_irq | output | 1 | Receive group request line |
| rx_vec | output | 8 | Receive vector |
| rx_vec_vld | output | 1 | Receive vector valid |
| tx_iack | input | 1 | Transmit group acknowledge strobe |
| tx_ein | input | 1 | Transmit group chain enable in |
| tx_eout | output | 1 | Transmit group chain enable out |
| tx_irq | output | 1 | Transmit group request line |
| tx_vec | output | 8 | Transmit vector |
| tx_vec_vld | output | 1 | Transmit vector valid |

## Verification
Pending flags, and with them the request lines and chain outputs, change one edge after an event or acknowledge. The vector and its valid flag appear one edge after the acknowledge. The bench drives every stimulus just after a falling edge, lets exactly one rising edge pass, and samples all outputs at the next falling edge. It advances its own pending model at that same point. Priority sweeps rotate and reverse the slot table over several request patterns and drain each group one acknowledge at a time. Every delivered vector is compared with a winner the bench computes from the slot rule.

// File: rtl/vic_pkg.sv
// Package: shared defaults for the dual-group vectored interrupt controller.
// Assumes: vectors are one byte wide; channel counts fit the index width.
package vic_pkg;
    localparam int VIC_RX_CH = 8;
    localparam int VIC_TX_CH = 3;
    localparam int VIC_VEC_W = 8;
endpackage

// File: rtl/vic_req_latch.sv
// Module: per-channel pending flags. A set pulse wins over a clear on the
// same edge so that an event arriving during delivery is not lost.
// Assumes: clr_i is at most one-hot and comes from the group responder.
module vic_req_latch #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] pend_o
);
    logic [N-1:0] pend_q;

    // Purpose: hold pending flags, clear on delivery, set on new event.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= (pend_q & ~clr_i) | set_i;
    end

    assign pend_o = pend_q;

    for (genvar g = 0; g < N; g++) begin : g_chk
        AST_EVENT_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
            set_i[g] |=> pend_o[g]); // R9
        AST_DELIVERY_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
            clr_i[g] && !set_i[g] |=> !pend_o[g]); // R9
    end
endmodule

// File: rtl/vic_prio_sel.sv
// Module: picks the winning channel among active requests.
// PROG=1: slot table, slot 0 highest, each slot names a channel.
// PROG=0: fixed order, channel 0 highest; the slot table is ignored.
// Assumes: in PROG mode the table is a permutation of the channels.
module vic_prio_sel #(
    parameter int N    = 8,
    parameter int IW   = 3,
    parameter bit PROG = 1'b1
) (
    input  logic [N-1:0]    active_i,
    input  logic [N*IW-1:0] prio_i,
    output logic            hit_o,
    output logic [IW-1:0]   idx_o
);
    localparam int SPAN = 1 << IW;

    if (PROG) begin : g_prog
        logic [SPAN-1:0] act_pad;

        // Purpose: widen the active vector so any slot value indexes safely.
        always_comb begin
            act_pad          = '0;
            act_pad[N-1:0]   = active_i;
        end

        // Purpose: scan slots from lowest priority up so slot 0 wins last.
        always_comb begin
            hit_o = 1'b0;
            idx_o = '0;
            for (int k = N - 1; k >= 0; k--) begin
                if (act_pad[prio_i[k*IW +: IW]]) begin
                    hit_o = 1'b1;
                    idx_o = prio_i[k*IW +: IW];
                end
            end
        end
    end else begin : g_fixed
        logic unused_prio;
        assign unused_prio = ^prio_i;

        // Purpose: lowest channel number among active requests wins.
        always_comb begin
            hit_o = 1'b0;
            idx_o = '0;
            for (int k = N - 1; k >= 0; k--) begin
                if (active_i[k]) begin
                    hit_o = 1'b1;
                    idx_o = IW'(k);
                end
            end
        end
    end
endmodule

// File: rtl/vic_group.sv
// Module: one interrupt group: pending flags, masking, arbitration, daisy
// chain pass-through and registered vector answer to an acknowledge.
// Assumes: iack is a strobe from the host side; ein comes from upstream.
module vic_group #(
    parameter int N    = 8,
    parameter int IW   = 3,
    parameter int VW   = 8,
    parameter bit PROG = 1'b1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N-1:0]    evt_i,
    input  logic [N-1:0]    mask_i,
    input  logic [N*IW-1:0] prio_i,
    input  logic [VW-1:0]   base_i,
    input  logic            iack_i,
    input  logic            ein_i,
    output logic            eout_o,
    output logic            irq_o,
    output logic [VW-1:0]   vec_o,
    output logic            vec_vld_o
);
    logic [N-1:0]  pend;
    logic [N-1:0]  active;
    logic [N-1:0]  clr;
    logic          hit;
    logic [IW-1:0] win;
    logic          deliver;
    logic [VW-1:0] vec_q;
    logic          vld_q;
    logic          unused_base;

    assign unused_base = ^base_i[IW-1:0];

    vic_req_latch #(.N(N)) u_latch (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (evt_i),
        .clr_i  (clr),
        .pend_o (pend)
    );

    assign active = pend & ~mask_i;

    vic_prio_sel #(.N(N), .IW(IW), .PROG(PROG)) u_sel (
        .active_i (active),
        .prio_i   (prio_i),
        .hit_o    (hit),
        .idx_o    (win)
    );

    // Purpose: answer only when enabled from upstream and holding a request.
    assign deliver = iack_i & ein_i & hit;

    // Purpose: one-hot clear of the delivered channel.
    always_comb begin
        clr = '0;
        if (deliver) clr[win] = 1'b1;
    end

    // Purpose: register the vector and its valid strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= 1'b0;
            vec_q <= '0;
        end else begin
            vld_q <= deliver;
            if (deliver) vec_q <= {base_i[VW-1:IW], win};
        end
    end

    assign irq_o     = hit;
    assign eout_o    = ein_i & ~hit;
    assign vec_o     = vec_q;
    assign vec_vld_o = vld_q;

    AST_WINNER_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> active[win]); // R7
    AST_VECTOR_NEEDS_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        vec_vld_o |-> $past(iack_i && ein_i)); // R6
    AST_VECTOR_INDEX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        vec_vld_o |-> (int'(vec_o[IW-1:0]) < N)); // R5

    for (genvar g = 0; g < N; g++) begin : g_mchk
        AST_MASK_KEEPS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
            pend[g] && mask_i[g] |=> pend[g]); // R3
    end
endmodule

// File: rtl/irq_vec_daisy.sv
// Module: top of the dual-group vectored interrupt controller. The receive
// group uses a programmable slot table; the transmit group a fixed order.
// Assumes: masks, slot table and bases are held stable by a register file.
module irq_vec_daisy
    import vic_pkg::*;
#(
    parameter int RX_CH = VIC_RX_CH,
    parameter int TX_CH = VIC_TX_CH,
    parameter int VEC_W = VIC_VEC_W
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [RX_CH-1:0]          rx_req,
    input  logic [TX_CH-1:0]          tx_req,
    input  logic [RX_CH-1:0]          rx_mask,
    input  logic [TX_CH-1:0]          tx_mask,
    input  logic [RX_CH*$clog2(RX_CH)-1:0] rx_prio,
    input  logic [VEC_W-1:0]          rx_vbase,
    input  logic [VEC_W-1:0]          tx_vbase,
    input  logic                      rx_iack,
    input  logic                      rx_ein,
    output logic                      rx_eout,
    output logic                      rx_irq,
    output logic [VEC_W-1:0]          rx_vec,
    output logic                      rx_vec_vld,
    input  logic                      tx_iack,
    input  logic                      tx_ein,
    output logic                      tx_eout,
    output logic                      tx_irq,
    output logic [VEC_W-1:0]          tx_vec,
    output logic                      tx_vec_vld
);
    localparam int RX_IW = $clog2(RX_CH);
    localparam int TX_IW = $clog2(TX_CH);

    vic_group #(.N(RX_CH), .IW(RX_IW), .VW(VEC_W), .PROG(1'b1)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt_i     (rx_req),
        .mask_i    (rx_mask),
        .prio_i    (rx_prio),
        .base_i    (rx_vbase),
        .iack_i    (rx_iack),
        .ein_i     (rx_ein),
        .eout_o    (rx_eout),
        .irq_o     (rx_irq),
        .vec_o     (rx_vec),
        .vec_vld_o (rx_vec_vld)
    );

    vic_group #(.N(TX_CH), .IW(TX_IW), .VW(VEC_W), .PROG(1'b0)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt_i     (tx_req),
        .mask_i    (tx_mask),
        .prio_i    ('0),
        .base_i    (tx_vbase),
        .iack_i    (tx_iack),
        .ein_i     (tx_ein),
        .eout_o    (tx_eout),
        .irq_o     (tx_irq),
        .vec_o     (tx_vec),
        .vec_vld_o (tx_vec_vld)
    );

    AST_IRQ_FALLS_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        rx_irq && rx_iack && rx_ein && ($countones(rx_req) == 0) && ($countones(rx_req | ~rx_mask) == 1) |=> !rx_irq); // R9
endmodule

// File: tb/irq_vec_daisy_test.sv
`timescale 1ns/1ps
module irq_vec_daisy_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [7:0]  rx_req, rx_mask, rx_vbase, tx_vbase;
    logic [2:0]  tx_req, tx_mask;
    logic [23:0] rx_prio;
    logic        rx_iack, rx_ein, tx_iack, tx_ein;
    logic        rx_eout, rx_irq, rx_vec_vld, tx_eout, tx_irq, tx_vec_vld;
    logic [7:0]  rx_vec, tx_vec;

    logic [7:0]  m_rx;
    logic [2:0]  m_tx;
    int          n_chk = 0;
    int          n_bad = 0;
    bit          done  = 1'b0;

    always #2 clk = ~clk;

    irq_vec_daisy uut (
        .clk(clk), .rst_n(rst_n), .rx_req(rx_req), .tx_req(tx_req),
        .rx_mask(rx_mask), .tx_mask(tx_mask), .rx_prio(rx_prio),
        .rx_vbase(rx_vbase), .tx_vbase(tx_vbase),
        .rx_iack(rx_iack), .rx_ein(rx_ein), .rx_eout(rx_eout), .rx_irq(rx_irq),
        .rx_vec(rx_vec), .rx_vec_vld(rx_vec_vld),
        .tx_iack(tx_iack), .tx_ein(tx_ein), .tx_eout(tx_eout), .tx_irq(tx_irq),
        .tx_vec(tx_vec), .tx_vec_vld(tx_vec_vld)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string what);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", what, act, exp);
        end
    endtask

    // Winner by slot table: lowest slot naming an active channel (R7).
    function automatic int rx_win(input logic [7:0] act, input logic [23:0] pr);
        for (int k = 0; k < 8; k++)
            if (act[pr[3*k +: 3]]) return int'(pr[3*k +: 3]);
        return -1;
    endfunction

    // Fixed order, channel 0 first (R8).
    function automatic int tx_win(input logic [2:0] act);
        for (int k = 0; k < 3; k++)
            if (act[k]) return k;
        return -1;
    endfunction

    // One cycle: drive after a falling edge, one rising edge, sample at the next falling edge.
    task automatic step(input logic [7:0] re, input logic [2:0] te, input logic ra, input logic ta);
        int rw, tw;
        logic rdel, tdel;
        rw   = rx_win(m_rx & ~rx_mask, rx_prio);
        tw   = tx_win(m_tx & ~tx_mask);
        rdel = ra && rx_ein && (rw >= 0);
        tdel = ta && tx_ein && (tw >= 0);
        rx_req = re; tx_req = te; rx_iack = ra; tx_iack = ta;
        @(posedge clk);
        @(negedge clk);
        rx_req = '0; tx_req = '0; rx_iack = 1'b0; tx_iack = 1'b0;
        if (rdel) m_rx[rw] = 1'b0;
        if (tdel) m_tx[tw] = 1'b0;
        m_rx = m_rx | re;
        m_tx = m_tx | te;
        chk(32'(rx_vec_vld), 32'(rdel), "R5/R6 rx vector valid");
        chk(32'(tx_vec_vld), 32'(tdel), "R5/R6 tx vector valid");
        if (rdel) chk(32'(rx_vec), 32'({rx_vbase[7:3], rw[2:0]}), "R7 rx vector");
        if (tdel) chk(32'(tx_vec), 32'({tx_vbase[7:2], tw[1:0]}), "R8 tx vector");
        chk(32'(rx_irq), 32'(|(m_rx & ~rx_mask)), "R2 rx request line");
        chk(32'(tx_irq), 32'(|(m_tx & ~tx_mask)), "R2 tx request line");
        chk(32'(rx_eout), 32'(rx_ein & ~|(m_rx & ~rx_mask)), "R4 rx chain out");
        chk(32'(tx_eout), 32'(tx_ein & ~|(m_tx & ~tx_mask)), "R4 tx chain out");
    endtask

    task automatic drain();
        int guard = 0;
        while ((|(m_rx & ~rx_mask) || |(m_tx & ~tx_mask)) && guard < 20) begin
            step('0, '0, 1'b1, 1'b1);
            guard++;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        rx_req = 8'hFF; tx_req = 3'h7; rx_mask = '0; tx_mask = '0;
        rx_vbase = 8'hA5; tx_vbase = 8'h57;
        rx_iack = 1'b0; tx_iack = 1'b0; rx_ein = 1'b1; tx_ein = 1'b1;
        for (int k = 0; k < 8; k++) rx_prio[3*k +: 3] = 3'(k);
        m_rx = '0; m_tx = '0;
        repeat (3) @(negedge clk);
        rx_req = '0; tx_req = '0;
        rst_n = 1'b1;
        @(negedge clk);
        // R10: events during reset were dropped, outputs idle.
        chk(32'(rx_irq), 0, "R10 rx line after reset");
        chk(32'(tx_irq), 0, "R10 tx line after reset");
        chk(32'(rx_vec_vld), 0, "R10 rx valid after reset");
        chk(32'(tx_vec_vld), 0, "R10 tx valid after reset");
        chk(32'(rx_eout), 1, "R10 rx chain passes after reset");

        // R1: each channel alone, then its vector.
        for (int c = 0; c < 8; c++) begin
            step(8'(1 << c), (c < 3) ? 3'(1 << c) : 3'b0, 1'b0, 1'b0);
            chk(32'(rx_irq), 1, "R1 rx event latched");
            step('0, '0, 1'b1, 1'b1);
        end

        // R7/R8: rotated and reversed slot tables over several patterns.
        for (int rev = 0; rev < 2; rev++) begin
            for (int rot = 0; rot < 8; rot++) begin
                for (int k = 0; k < 8; k++)
                    rx_prio[3*k +: 3] = rev ? 3'(7 - ((k + rot) % 8)) : 3'((k + rot) % 8);
                for (int p = 0; p < 4; p++) begin
                    logic [7:0] pat;
                    pat = (p == 0) ? 8'hFF : (p == 1) ? 8'h5A : (p == 2) ? 8'h81 : 8'h3C;
                    step(pat, 3'(pat + 8'(rot)), 1'b0, 1'b0);
                    drain();
                end
            end
        end

        // R3: masked channels stay pending but invisible.
        rx_mask = 8'hF0; tx_mask = 3'b101;
        step(8'hFF, 3'h7, 1'b0, 1'b0);
        drain();
        chk(32'(rx_irq), 0, "R3 rx masked line low");
        step('0, '0, 1'b1, 1'b1);
        rx_mask = '0; tx_mask = '0;
        step('0, '0, 1'b0, 1'b0);
        chk(32'(rx_irq), 1, "R3 rx unmask restores request");
        chk(32'(tx_irq), 1, "R3 tx unmask restores request");
        drain();

        // R6/R4: enable input low blocks the answer.
        rx_ein = 1'b0; tx_ein = 1'b0;
        step(8'h24, 3'h2, 1'b0, 1'b0);
        step('0, '0, 1'b1, 1'b1);
        chk(32'(m_rx), 32'h24, "R6 rx flags kept model");
        chk(32'(rx_irq), 1, "R6 rx request kept");
        rx_ein = 1'b1; tx_ein = 1'b1;
        drain();
        step('0, '0, 1'b1, 1'b1); // R6: acknowledge with nothing pending

        // R9: new event on the delivery edge survives.
        step(8'h20, 3'h1, 1'b0, 1'b0);
        step(8'h20, 3'h1, 1'b1, 1'b1);
        chk(32'(rx_irq), 1, "R9 rx re-event survives clear");
        chk(32'(tx_irq), 1, "R9 tx re-event survives clear");
        drain();

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule